// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits next to a small cluster of cores and turns the interrupt sources that belong to each core into one IRQ line and one FIQ line per core, plus a pending-status word per core that software reads to find out which source fired. Each core has its own group of timer lines, its own group of mailbox lines and its own performance-monitor line. One system-level "GPU" interrupt is shared by the whole cluster and is steered to a single chosen core. An AXI error line and a local-timer line are reported on core 0.

Software programs the router through a simple 32-bit register port with byte addresses. It can enable each timer as IRQ or FIQ per core, choose the core that receives the shared interrupt, and set or clear the performance-monitor enables through separate set and clear aliases. Pending bits are plain levels that track their sources. The router does not latch them, so software clears an interrupt at its source.

Top module: `lir_router`

## Requirements
- R1: After synchronous reset, all timer enables, performance-monitor enables, the control word and the prescaler word are 0. The shared interrupt is routed to core 0 for both IRQ and FIQ, and `irq_o`, `fiq_o` and `bus_rdata` are 0.
- R2: The timer configuration register of core n is at byte offset 0x40+4n. Bit t (t = 0..3) enables timer t of that core onto its IRQ line. Bit t+4 enables the same timer onto its FIQ line. The register reads back its 8 bits.
- R3: In the routing register at offset 0x0C, bits [1:0] name the core that receives the shared interrupt as IRQ and bits [3:2] name the core that receives it as FIQ. A raised shared interrupt reaches exactly one core's IRQ line and exactly one core's FIQ line.
- R4: Writing to offset 0x10 sets every performance-monitor enable whose bit is 1. Writing to offset 0x14 clears every such enable. Other enables are unchanged. Bit n routes core n's monitor line to its IRQ and bit n+4 routes it to its FIQ. A read of either offset returns the current enable mask.
- R5: The read-only pending word of core n is at offset 0x60+4n. Its layout is: bits 0..3 for timers 0..3, bits 4..7 for mailboxes 0..3, bit 8 for the shared interrupt (only on a core it is routed to as IRQ or FIQ), bit 9 for the monitor line, bit 10 for AXI error and bit 11 for the local timer. Bits 10 and 11 appear on core 0 only. Every bit follows its source level.
- R6: Any mailbox line of core n raises that core's IRQ with no enable. The AXI error and local-timer lines raise core 0's IRQ. None of these ever raises an FIQ.
- R7: The control word at 0x00 and the prescaler word at 0x08 store all 32 written bits and read them back, for example 0x80000000 for the 19.2 MHz timebase.
- R8: Writes to pending words, to unmapped offsets or to addresses not aligned to 4 bytes change no state. Reads of unmapped or misaligned addresses return 0.
- R9: `irq_o` and `fiq_o` are registered. They reflect sources and enables one clock after the sources change, and they drop one clock after the source drops. Read data appears the clock after `bus_rd` and holds until the next read.
- R10: Writing 0 to the routing register sends both the IRQ and the FIQ of the shared interrupt back to core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tmr_src | input | 16 | Timer lines, 4 per core, core n at [4n+3:4n] |
| mbox_src | input | 16 | Mailbox lines, 4 per core, core n at [4n+3:4n] |
| gpu_src | input | 1 | Shared interrupt line |
| pmu_src | input | 4 | Performance-monitor line per core |
| axi_src | input | 1 | AXI error line (core 0) |
| ltmr_src | input | 1 | Local timer line (core 0) |
| irq_o | output | 4 | IRQ line per core |
| fiq_o | output | 4 | FIQ line per core |

## Verification
The bench targets the places where routing usually goes wrong. The shared interrupt is moved to a core other than core 0 for IRQ and to yet another core for FIQ. If the two selector fields were swapped or merged, the interrupt would reach the wrong core, or both lines would land on the same core. The set and clear aliases are applied to a mask that is already partly set, so a design that overwrote the mask instead of setting or clearing bits would lose enables. The mask is also read through the clear alias, which catches a design that reads back 0 there. Two cores with different patterns are read as pending words, which catches misplaced bit fields and AXI or local-timer bits leaking onto another core. Writes to a pending word, to an unmapped address and to a misaligned address are followed by readbacks, which exposes any decode that aliases them onto live registers. The bench also checks that each output rises exactly one clock after its source and drops one clock after the source falls.

// File: rtl/lir_pkg.sv
package lir_pkg;

  localparam int REG_ADDR_W = 8;

  localparam logic [REG_ADDR_W-1:0] OFS_CTRL    = 8'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_PRESC   = 8'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_GPU     = 8'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_PMU_SET = 8'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_PMU_CLR = 8'h14;
  localparam logic [3:0]            PAGE_TCFG   = 4'h4;
  localparam logic [3:0]            PAGE_PEND   = 4'h6;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_PRESC,
    RK_GPU,
    RK_PMU_SET,
    RK_PMU_CLR,
    RK_TCFG,
    RK_PEND
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [REG_ADDR_W-1:0] a,
                                           input int ncores);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.idx  = '0;
    if (a[1:0] == 2'b00) begin
      if (a == OFS_CTRL)           s.kind = RK_CTRL;
      else if (a == OFS_PRESC)     s.kind = RK_PRESC;
      else if (a == OFS_GPU)       s.kind = RK_GPU;
      else if (a == OFS_PMU_SET)   s.kind = RK_PMU_SET;
      else if (a == OFS_PMU_CLR)   s.kind = RK_PMU_CLR;
      else if (int'(a[3:2]) < ncores) begin
        if (a[7:4] == PAGE_TCFG) begin
          s.kind = RK_TCFG;
          s.idx  = {2'b00, a[3:2]};
        end else if (a[7:4] == PAGE_PEND) begin
          s.kind = RK_PEND;
          s.idx  = {2'b00, a[3:2]};
        end
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/lir_regs.sv
module lir_regs
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TMR_N     = 4,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr,
  input  logic                                   rd,
  input  logic [REG_ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                      wdata,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]       pend_words,
  output logic [DATA_W-1:0]                      rdata,
  output logic [NUM_CORES-1:0][2*TMR_N-1:0]      tcfg,
  output logic [SEL_W-1:0]                       gpu_irq_sel,
  output logic [SEL_W-1:0]                       gpu_fiq_sel,
  output logic [NUM_CORES-1:0]                   pmu_irq_en,
  output logic [NUM_CORES-1:0]                   pmu_fiq_en
);

  localparam int TCFG_W = 2 * TMR_N;
  localparam int PMU_W  = 2 * NUM_CORES;
  localparam int GPU_W  = 2 * SEL_W;

  reg_sel_t                          sel;
  logic [DATA_W-1:0]                 ctrl_q;
  logic [DATA_W-1:0]                 presc_q;
  logic [NUM_CORES-1:0][TCFG_W-1:0]  tcfg_q;
  logic [SEL_W-1:0]                  gpu_irq_q;
  logic [SEL_W-1:0]                  gpu_fiq_q;
  logic [NUM_CORES-1:0]              pmu_irq_q;
  logic [NUM_CORES-1:0]              pmu_fiq_q;
  logic [DATA_W-1:0]                 rd_val;

  assign sel = decode_addr(addr, NUM_CORES);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      presc_q   <= '0;
      tcfg_q    <= '0;
      gpu_irq_q <= '0;
      gpu_fiq_q <= '0;
      pmu_irq_q <= '0;
      pmu_fiq_q <= '0;
    end else if (wr) begin
      case (sel.kind)
        RK_CTRL:    ctrl_q  <= wdata;
        RK_PRESC:   presc_q <= wdata;
        RK_GPU: begin
          gpu_irq_q <= wdata[SEL_W-1:0];
          gpu_fiq_q <= wdata[GPU_W-1:SEL_W];
        end
        RK_PMU_SET: begin
          pmu_irq_q <= pmu_irq_q | wdata[NUM_CORES-1:0];
          pmu_fiq_q <= pmu_fiq_q | wdata[PMU_W-1:NUM_CORES];
        end
        RK_PMU_CLR: begin
          pmu_irq_q <= pmu_irq_q & ~wdata[NUM_CORES-1:0];
          pmu_fiq_q <= pmu_fiq_q & ~wdata[PMU_W-1:NUM_CORES];
        end
        RK_TCFG: begin
          for (int c = 0; c < NUM_CORES; c++) begin
            if (sel.idx == 4'(c)) tcfg_q[c] <= wdata[TCFG_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      RK_CTRL:                rd_val = ctrl_q;
      RK_PRESC:               rd_val = presc_q;
      RK_GPU:                 rd_val[GPU_W-1:0] = {gpu_fiq_q, gpu_irq_q};
      RK_PMU_SET, RK_PMU_CLR: rd_val[PMU_W-1:0] = {pmu_fiq_q, pmu_irq_q};
      RK_TCFG: begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (sel.idx == 4'(c)) rd_val[TCFG_W-1:0] = tcfg_q[c];
        end
      end
      RK_PEND: begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (sel.idx == 4'(c)) rd_val = pend_words[c];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end

  assign tcfg        = tcfg_q;
  assign gpu_irq_sel = gpu_irq_q;
  assign gpu_fiq_sel = gpu_fiq_q;
  assign pmu_irq_en  = pmu_irq_q;
  assign pmu_fiq_en  = pmu_fiq_q;

endmodule

// File: rtl/lir_core_route.sv
module lir_core_route #(
  parameter int TMR_N  = 4,
  parameter int MBOX_N = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TMR_N-1:0]     tmr,
  input  logic [MBOX_N-1:0]    mbox,
  input  logic [2*TMR_N-1:0]   tcfg,
  input  logic                 gpu_irq_hit,
  input  logic                 gpu_fiq_hit,
  input  logic                 pmu,
  input  logic                 pmu_irq_en,
  input  logic                 pmu_fiq_en,
  input  logic [1:0]           shared,
  output logic [DATA_W-1:0]    pend_word,
  output logic                 irq,
  output logic                 fiq
);

  localparam int MBOX_LSB = TMR_N;
  localparam int GPU_BIT  = TMR_N + MBOX_N;
  localparam int PMU_BIT  = GPU_BIT + 1;
  localparam int AXI_BIT  = GPU_BIT + 2;
  localparam int LTMR_BIT = GPU_BIT + 3;

  logic irq_d;
  logic fiq_d;

  always_comb begin
    pend_word                    = '0;
    pend_word[TMR_N-1:0]         = tmr;
    pend_word[MBOX_LSB +: MBOX_N] = mbox;
    pend_word[GPU_BIT]           = gpu_irq_hit | gpu_fiq_hit;
    pend_word[PMU_BIT]           = pmu;
    pend_word[AXI_BIT]           = shared[0];
    pend_word[LTMR_BIT]          = shared[1];
  end

  assign irq_d = (|(tmr & tcfg[TMR_N-1:0])) | (|mbox) | gpu_irq_hit |
                 (pmu & pmu_irq_en) | (|shared);
  assign fiq_d = (|(tmr & tcfg[2*TMR_N-1:TMR_N])) | gpu_fiq_hit |
                 (pmu & pmu_fiq_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      fiq <= 1'b0;
    end else begin
      irq <= irq_d;
      fiq <= fiq_d;
    end
  end

endmodule

// File: rtl/lir_router.sv
module lir_router
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TMR_N     = 4,
  parameter int MBOX_N    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [REG_ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_CORES*TMR_N-1:0]    tmr_src,
  input  logic [NUM_CORES*MBOX_N-1:0]   mbox_src,
  input  logic                          gpu_src,
  input  logic [NUM_CORES-1:0]          pmu_src,
  input  logic                          axi_src,
  input  logic                          ltmr_src,
  output logic [NUM_CORES-1:0]          irq_o,
  output logic [NUM_CORES-1:0]          fiq_o
);

  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0][DATA_W-1:0]   pend_words;
  logic [NUM_CORES-1:0][2*TMR_N-1:0]  tcfg;
  logic [SEL_W-1:0]                   gpu_irq_sel;
  logic [SEL_W-1:0]                   gpu_fiq_sel;
  logic [NUM_CORES-1:0]               pmu_irq_en;
  logic [NUM_CORES-1:0]               pmu_fiq_en;

  lir_regs #(
    .NUM_CORES (NUM_CORES),
    .TMR_N     (TMR_N),
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .pend_words  (pend_words),
    .rdata       (bus_rdata),
    .tcfg        (tcfg),
    .gpu_irq_sel (gpu_irq_sel),
    .gpu_fiq_sel (gpu_fiq_sel),
    .pmu_irq_en  (pmu_irq_en),
    .pmu_fiq_en  (pmu_fiq_en)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic       irq_hit;
    logic       fiq_hit;
    logic [1:0] shared;

    assign irq_hit = gpu_src && (gpu_irq_sel == SEL_W'(c));
    assign fiq_hit = gpu_src && (gpu_fiq_sel == SEL_W'(c));

    if (c == 0) begin : g_shared
      assign shared = {ltmr_src, axi_src};
    end else begin : g_noshared
      assign shared = 2'b00;
    end

    lir_core_route #(
      .TMR_N  (TMR_N),
      .MBOX_N (MBOX_N),
      .DATA_W (DATA_W)
    ) u_route (
      .clk         (clk),
      .rst         (rst),
      .tmr         (tmr_src[c*TMR_N +: TMR_N]),
      .mbox        (mbox_src[c*MBOX_N +: MBOX_N]),
      .tcfg        (tcfg[c]),
      .gpu_irq_hit (irq_hit),
      .gpu_fiq_hit (fiq_hit),
      .pmu         (pmu_src[c]),
      .pmu_irq_en  (pmu_irq_en[c]),
      .pmu_fiq_en  (pmu_fiq_en[c]),
      .shared      (shared),
      .pend_word   (pend_words[c]),
      .irq         (irq_o[c]),
      .fiq         (fiq_o[c])
    );
  end

endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk #(
  parameter int NUM_CORES = 4,
  parameter int TMR_N     = 4,
  parameter int MBOX_N    = 4,
  parameter int DATA_W    = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_rd,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic [NUM_CORES*TMR_N-1:0]    tmr_src,
  input logic [NUM_CORES*MBOX_N-1:0]   mbox_src,
  input logic                          gpu_src,
  input logic [NUM_CORES-1:0]          pmu_src,
  input logic                          axi_src,
  input logic                          ltmr_src,
  input logic [NUM_CORES-1:0]          irq_o,
  input logic [NUM_CORES-1:0]          fiq_o
);

  logic all_quiet;
  logic only_gpu;
  logic no_fiq_src;

  assign no_fiq_src = (tmr_src == '0) && !gpu_src && (pmu_src == '0);
  assign all_quiet  = no_fiq_src && (mbox_src == '0) && !axi_src && !ltmr_src;
  assign only_gpu   = gpu_src && (tmr_src == '0) && (mbox_src == '0) &&
                      (pmu_src == '0) && !axi_src && !ltmr_src;

  AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (rst)
    all_quiet |=> (irq_o == '0) && (fiq_o == '0)); // R9

  AST_NO_FIQ_FROM_UNGATED: assert property (@(posedge clk) disable iff (rst)
    no_fiq_src |=> (fiq_o == '0)); // R6

  AST_GPU_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    only_gpu |=> ($countones(irq_o) == 1) && ($countones(fiq_o) == 1)); // R3

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R9

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_mbox
    AST_MBOX_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
      (|mbox_src[c*MBOX_N +: MBOX_N]) |=> irq_o[c]); // R6
  end

endmodule

bind lir_router lir_router_chk #(
  .NUM_CORES (NUM_CORES),
  .TMR_N     (TMR_N),
  .MBOX_N    (MBOX_N),
  .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/lir_router_tb_top.sv
module lir_router_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_src = '0;
  logic [15:0] mbox_src = '0;
  logic        gpu_src = 1'b0;
  logic [3:0]  pmu_src = '0;
  logic        axi_src = 1'b0;
  logic        ltmr_src = 1'b0;
  logic [3:0]  irq_o;
  logic [3:0]  fiq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit live   = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [7:0]  m_tcfg [4];
  logic [3:0]  m_route;
  logic [7:0]  m_pmu;
  logic [31:0] m_ctrl, m_presc;
  logic [3:0]  exp_irq, exp_fiq;
  logic [31:0] exp_rdata;

  always #4 clk = ~clk;

  lir_router dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_src(tmr_src), .mbox_src(mbox_src), .gpu_src(gpu_src),
    .pmu_src(pmu_src), .axi_src(axi_src), .ltmr_src(ltmr_src),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] m_pend(int n);
    logic [31:0] w = '0;
    w[3:0] = tmr_src[4*n +: 4];
    w[7:4] = mbox_src[4*n +: 4];
    w[8]   = gpu_src && ((int'(m_route[1:0]) == n) || (int'(m_route[3:2]) == n));
    w[9]   = pmu_src[n];
    if (n == 0) begin
      w[10] = axi_src;
      w[11] = ltmr_src;
    end
    return w;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a)
      8'h00: return m_ctrl;
      8'h08: return m_presc;
      8'h0C: return {28'h0, m_route};
      8'h10, 8'h14: return {24'h0, m_pmu};
      8'h40, 8'h44, 8'h48, 8'h4C: return {24'h0, m_tcfg[a[3:2]]};
      8'h60, 8'h64, 8'h68, 8'h6C: return m_pend(int'(a[3:2]));
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_tcfg[i]) m_tcfg[i] = '0;
      m_route = '0; m_pmu = '0; m_ctrl = '0; m_presc = '0;
      exp_irq = '0; exp_fiq = '0; exp_rdata = '0;
      live = 1;
    end else begin
      for (int n = 0; n < 4; n++) begin
        exp_irq[n] = ((tmr_src[4*n +: 4] & m_tcfg[n][3:0]) != 0) ||
                     (mbox_src[4*n +: 4] != 0) ||
                     (gpu_src && int'(m_route[1:0]) == n) ||
                     (pmu_src[n] && m_pmu[n]) ||
                     (n == 0 && (axi_src || ltmr_src));
        exp_fiq[n] = ((tmr_src[4*n +: 4] & m_tcfg[n][7:4]) != 0) ||
                     (gpu_src && int'(m_route[3:2]) == n) ||
                     (pmu_src[n] && m_pmu[n+4]);
      end
      if (bus_rd) exp_rdata = m_read(bus_addr);
      if (bus_wr && bus_addr[1:0] == 2'b00) begin
        case (bus_addr)
          8'h00: m_ctrl = bus_wdata;
          8'h08: m_presc = bus_wdata;
          8'h0C: m_route = bus_wdata[3:0];
          8'h10: m_pmu = m_pmu | bus_wdata[7:0];
          8'h14: m_pmu = m_pmu & ~bus_wdata[7:0];
          8'h40, 8'h44, 8'h48, 8'h4C: m_tcfg[bus_addr[3:2]] = bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      n_chk++;
      if (irq_o !== exp_irq || fiq_o !== exp_fiq || bus_rdata !== exp_rdata) begin
        n_fail++;
        $display("FAIL %s model: irq %h/%h fiq %h/%h rdata %h/%h (act/exp)",
                 cur_req, irq_o, exp_irq, fiq_o, exp_fiq, bus_rdata, exp_rdata);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, enables off even with sources active
    cur_req = "R1";
    check("R1 irq", {28'h0, irq_o}, 32'h0);
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h0C, 32'h0, "R1 route");
    rd(8'h10, 32'h0, "R1 pmu");
    rd(8'h44, 32'h0, "R1 tcfg1");
    tmr_src = 16'hFFFF; pmu_src = 4'hF;
    settle();
    check("R1 gated irq", {28'h0, irq_o}, 32'h0);
    check("R1 gated fiq", {28'h0, fiq_o}, 32'h0);
    tmr_src = '0; pmu_src = '0;

    // R7: control and prescaler storage
    cur_req = "R7";
    wr(8'h08, 32'h8000_0000);
    wr(8'h00, 32'hA5C3_0001);
    rd(8'h08, 32'h8000_0000, "R7 presc");
    rd(8'h00, 32'hA5C3_0001, "R7 ctrl");

    // R2: timer enables on core 1
    cur_req = "R2";
    wr(8'h44, 32'h0000_0021);
    rd(8'h44, 32'h21, "R2 readback");
    tmr_src = 16'h0010;
    settle();
    check("R2 t0 irq", {28'h0, irq_o}, 32'h2);
    check("R2 t0 fiq", {28'h0, fiq_o}, 32'h0);
    tmr_src = 16'h0020;
    settle();
    check("R2 t1 fiq", {28'h0, fiq_o}, 32'h2);
    check("R2 t1 irq", {28'h0, irq_o}, 32'h0);
    tmr_src = 16'h0040;
    settle();
    check("R2 t2 off", {24'h0, irq_o, fiq_o}, 32'h0);
    tmr_src = '0;

    // R3: shared interrupt steered to cores 2 (IRQ) and 3 (FIQ)
    cur_req = "R3";
    wr(8'h0C, 32'h0000_000E);
    gpu_src = 1'b1;
    settle();
    check("R3 irq", {28'h0, irq_o}, 32'h4);
    check("R3 fiq", {28'h0, fiq_o}, 32'h8);
    rd(8'h68, 32'h100, "R3 pend core2");
    rd(8'h6C, 32'h100, "R3 pend core3");
    rd(8'h60, 32'h0, "R3 pend core0");

    // R10: writing 0 returns route to core 0
    cur_req = "R10";
    wr(8'h0C, 32'h0);
    settle();
    check("R10 irq", {28'h0, irq_o}, 32'h1);
    check("R10 fiq", {28'h0, fiq_o}, 32'h1);
    gpu_src = 1'b0;

    // R4: set and clear aliases
    cur_req = "R4";
    wr(8'h10, 32'h03);
    wr(8'h10, 32'h40);
    rd(8'h14, 32'h43, "R4 read via clear");
    wr(8'h14, 32'h01);
    rd(8'h10, 32'h42, "R4 after clear");
    pmu_src = 4'hF;
    settle();
    check("R4 irq", {28'h0, irq_o}, 32'h2);
    check("R4 fiq", {28'h0, fiq_o}, 32'h4);
    pmu_src = '0;

    // R5: pending layouts of two cores
    cur_req = "R5";
    tmr_src = 16'hA005; mbox_src = 16'h8003; pmu_src = 4'h1;
    axi_src = 1'b1; ltmr_src = 1'b1; gpu_src = 1'b1;
    rd(8'h60, 32'h0000_0F35, "R5 core0");
    rd(8'h6C, 32'h0000_008A, "R5 core3");
    tmr_src = '0; mbox_src = '0; pmu_src = '0;
    axi_src = 1'b0; ltmr_src = 1'b0; gpu_src = 1'b0;

    // R6: mailbox and core-0-only lines
    cur_req = "R6";
    mbox_src = 16'h0200;
    settle();
    check("R6 mbox irq", {28'h0, irq_o}, 32'h4);
    check("R6 mbox fiq", {28'h0, fiq_o}, 32'h0);
    mbox_src = '0; axi_src = 1'b1;
    settle();
    check("R6 axi irq", {28'h0, irq_o}, 32'h1);
    axi_src = 1'b0; ltmr_src = 1'b1;
    settle();
    check("R6 ltmr irq", {28'h0, irq_o}, 32'h1);
    ltmr_src = 1'b0;

    // R8: ignored writes, zero reads
    cur_req = "R8";
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h45, 32'h0000_00FF);
    rd(8'h44, 32'h21, "R8 tcfg1 intact");
    rd(8'h0C, 32'h0, "R8 route intact");
    rd(8'h20, 32'h0, "R8 unmapped");
    rd(8'h09, 32'h0, "R8 misaligned");
    rd(8'h64, 32'h0, "R8 pend core1");

    // R9: one-clock latency, level following
    cur_req = "R9";
    @(negedge clk);
    tmr_src = 16'h0010;
    @(negedge clk);
    check("R9 rise", {31'h0, irq_o[1]}, 32'h1);
    tmr_src = '0;
    @(negedge clk);
    check("R9 fall", {31'h0, irq_o[1]}, 32'h0);

    settle();
    finish_run();
  end

endmodule